// File: doc/BRIEF.md
# USB Slave-FIFO Loopback Controller

This block sits on the FPGA side of a USB bridge chip whose endpoint buffers are set up as slave FIFOs that are clocked from outside. It acts as the bus master of that interface. It pulls words out of the bridge's OUT endpoint FIFO into a local 256-entry buffer. It then turns the shared data bus around and pushes the same words, in the same order, into the bridge's IN endpoint FIFO. The host sees its own data come back.

Traffic is held off until the bridge raises a sync input. If words were sent straight after FPGA configuration, before the host-side firmware is ready, the returned stream would be corrupted. A done output rises as soon as reset is released, so bridge firmware can poll it before it switches to the FPGA-supplied interface clock. When a read phase ends because the OUT FIFO ran dry, which means a short packet, the block commits that packet with a one-cycle packet-end pulse after the buffer has drained.

Top module: `usb_fifo_echo`

## Requirements
- R1: While `rst_n` is low, `rd_n`, `wr_n`, `oe_n` and `pktend_n` are all high, `done` is low and the block does not drive `fdq`.
- R2: `done` is high from the first clock edge after `rst_n` rises and stays high.
- R3: Until `sync` has been seen high at a clock edge, the block asserts no read, write or output-enable strobe and leaves `fdq` released.
- R4: A read strobe (`rd_n` low) occurs only while `oe_n` is low, `fifo_sel` is 2'b00 (OUT endpoint) and `out_has_data` is high. `oe_n` is already low in the cycle before each falling edge of `rd_n`.
- R5: The local buffer never holds more than 256 words. A read phase stops once it is full, and a 300-word burst reaches a peak occupancy of exactly 256.
- R6: `wr_n` is low only in the write phase, with `in_has_room` high, the buffer non-empty, `oe_n` high and `fifo_sel` equal to 2'b10 (IN endpoint).
- R7: The block drives `fdq` only in the write phase, never while `oe_n` is low.
- R8: A read phase moves to writing when the buffer is full, or when `out_has_data` is low and the buffer is non-empty. The write phase empties the buffer completely and then returns to reading through one output-enable cycle.
- R9: After a buffer that ended its read phase on an empty OUT FIFO has been drained, `pktend_n` is low for exactly one cycle, with `in_has_room` high and `fifo_sel` 2'b10. After a buffer that ended full, no pulse is given.
- R10: The words written to the IN endpoint equal the words read from the OUT endpoint, in order, under any pattern of `in_has_room` throttling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock shared with the bridge |
| rst_n | input | 1 | Active-low synchronous reset |
| sync | input | 1 | Bridge ready indication; gates all traffic |
| out_has_data | input | 1 | Flag: OUT FIFO holds at least one word |
| in_has_room | input | 1 | Flag: IN FIFO can accept a word |
| fdq | inout | WIDTH | Bidirectional FIFO data bus (16 by default, 8 selectable) |
| fifo_sel | output | 2 | Endpoint select: 2'b00 OUT, 2'b10 IN |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| oe_n | output | 1 | Active-low bridge output enable |
| pktend_n | output | 1 | Active-low short-packet commit |
| done | output | 1 | High once the block is out of reset |

## Verification
The hardest situation to reach is a full buffer that meets a throttled IN FIFO. Reaching it requires exactly 256 or more queued words while the room flag drops at random inside the write phase. The bench model of the bridge queues bursts of 256 and 300 words and withholds room on roughly a quarter of the cycles, so both the full-ended and the empty-ended endings of a read phase occur, with stalls in the middle of a drain. Single words released a few cycles apart force many short read phases and check the packet-end pulse and the turnaround path again and again.

// File: rtl/usb_fifo_echo.sv
module usb_fifo_echo #(
  parameter int WIDTH    = 16,
  parameter int DEPTH    = 256,
  parameter logic [1:0] OUT_EP = 2'b00,
  parameter logic [1:0] IN_EP  = 2'b10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic             out_has_data,
  input  logic             in_has_room,
  inout  wire  [WIDTH-1:0] fdq,
  output logic [1:0]       fifo_sel,
  output logic             rd_n,
  output logic             wr_n,
  output logic             oe_n,
  output logic             pktend_n,
  output logic             done
);
  localparam int AW = $clog2(DEPTH);

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_WAIT = 3'd1;
  localparam logic [2:0] S_PRE  = 3'd2;
  localparam logic [2:0] S_READ = 3'd3;
  localparam logic [2:0] S_TURN = 3'd4;
  localparam logic [2:0] S_WRITE = 3'd5;

  logic [2:0]       st, st_nx;
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;
  logic             short_q;
  logic [WIDTH-1:0] mem [DEPTH];

  wire full   = (cnt == (AW+1)'(DEPTH));
  wire empty  = (cnt == '0);
  wire do_rd  = (st == S_READ) && out_has_data && !full;
  wire do_wr  = (st == S_WRITE) && in_has_room && !empty;
  wire do_pkt = (st == S_WRITE) && empty && short_q && in_has_room;
  wire drv_en = (st == S_WRITE);

  assign fdq      = drv_en ? mem[rp] : 'z;
  assign rd_n     = !do_rd;
  assign wr_n     = !do_wr;
  assign pktend_n = !do_pkt;
  assign oe_n     = !((st == S_PRE) || (st == S_READ));
  assign fifo_sel = ((st == S_TURN) || (st == S_WRITE)) ? IN_EP : OUT_EP;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  st_nx = S_WAIT;
      S_WAIT:  if (sync) st_nx = S_PRE;
      S_PRE:   st_nx = S_READ;
      S_READ:  if (full || (!out_has_data && !empty)) st_nx = S_TURN;
      S_TURN:  st_nx = S_WRITE;
      S_WRITE: if (empty && (!short_q || in_has_room)) st_nx = S_PRE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      wp      <= '0;
      rp      <= '0;
      cnt     <= '0;
      short_q <= 1'b0;
      done    <= 1'b0;
    end else begin
      st   <= st_nx;
      done <= 1'b1;
      if (st == S_READ && st_nx == S_TURN) short_q <= !full;
      if (do_rd) begin
        wp  <= wp + 1'b1;
        cnt <= cnt + 1'b1;
      end else if (do_wr) begin
        rp  <= rp + 1'b1;
        cnt <= cnt - 1'b1;
      end
    end
  end

  always_ff @(posedge clk)
    if (do_rd) mem[wp] <= fdq;

endmodule

// File: rtl/usb_fifo_echo_chk.sv
module usb_fifo_echo_chk #(
  parameter int DEPTH = 256,
  parameter int AW = 8,
  parameter logic [1:0] OUT_EP = 2'b00,
  parameter logic [1:0] IN_EP  = 2'b10
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic       oe_n,
  input logic       pktend_n,
  input logic [1:0] fifo_sel,
  input logic       out_has_data,
  input logic       in_has_room,
  input logic [2:0] st,
  input logic       drv_en,
  input logic [AW:0] cnt
);
  p_rd_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> (!oe_n && fifo_sel == OUT_EP && out_has_data));
  p_oe_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> $past(!oe_n));
  p_wr_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_n |-> (in_has_room && oe_n && fifo_sel == IN_EP && cnt != '0));
  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !drv_en);
  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st < 3'd2) |-> (rd_n && wr_n && oe_n && !drv_en));
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= (AW+1)'(DEPTH));
  p_pktend_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pktend_n |-> (in_has_room && fifo_sel == IN_EP && wr_n));
  p_pktend_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pktend_n |=> pktend_n);
endmodule

bind usb_fifo_echo usb_fifo_echo_chk #(
  .DEPTH(DEPTH), .AW(AW), .OUT_EP(OUT_EP), .IN_EP(IN_EP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .wr_n(wr_n), .oe_n(oe_n),
  .pktend_n(pktend_n), .fifo_sel(fifo_sel), .out_has_data(out_has_data),
  .in_has_room(in_has_room), .st(st), .drv_en(drv_en), .cnt(cnt)
);

// File: tb/usb_fifo_echo_test.sv
`timescale 1ns/100ps
module usb_fifo_echo_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync = 1'b0;
  logic        flag_a = 1'b0;
  logic        flag_d = 1'b0;
  wire  [15:0] fdq;
  logic [1:0]  fifo_sel;
  logic        rd_n, wr_n, oe_n, pktend_n, done;

  logic [15:0] tb_drv = '0;
  logic        tb_en = 1'b0;
  assign fdq = tb_en ? tb_drv : 'z;

  int total = 0, bad = 0;
  int out_q[$], exp_q[$];
  int got_cnt = 0, occ = 0, peak = 0, pk_cnt = 0, early = 0;
  int seq = 0;
  bit throttle = 1'b0;
  bit prev_oe_n = 1'b1;

  always #2 clk = ~clk;

  usb_fifo_echo uut (
    .clk(clk), .rst_n(rst_n), .sync(sync), .out_has_data(flag_a),
    .in_has_room(flag_d), .fdq(fdq), .fifo_sel(fifo_sel), .rd_n(rd_n),
    .wr_n(wr_n), .oe_n(oe_n), .pktend_n(pktend_n), .done(done)
  );

  function automatic int pat(int k);
    return (k * 40503 + 16'h5A3C) & 16'hFFFF;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always begin
    @(negedge clk);
    flag_a = (out_q.size() > 0);
    flag_d = throttle ? (($urandom % 4) != 0) : 1'b1;
    tb_en  = !oe_n && fifo_sel == 2'b00;
    tb_drv = (out_q.size() > 0) ? 16'(out_q[0]) : 16'hDEAD;
    #1.5;
    if (rst_n) begin
      if (!sync && (!rd_n || !wr_n || !oe_n)) early++;
      if (!rd_n) begin
        chk(flag_a && !oe_n && fifo_sel == 2'b00 && !prev_oe_n, "R4 read gating", {oe_n, fifo_sel}, 0);
        if (out_q.size() > 0) void'(out_q.pop_front());
        occ++;
        if (occ > peak) peak = occ;
      end
      if (!wr_n) begin
        chk(flag_d && oe_n && fifo_sel == 2'b10, "R6 write gating", {flag_d, oe_n, fifo_sel}, 3'b110);
        chk(!$isunknown(fdq), "R7 bus driven", int'(fdq), 0);
        if (exp_q.size() > 0) begin
          int e;
          e = exp_q.pop_front();
          chk(int'(fdq) == e, "R10 data order", int'(fdq), e);
        end else chk(0, "R10 extra word", int'(fdq), 0);
        got_cnt++;
        occ--;
      end
      if (!pktend_n) begin
        chk(flag_d && fifo_sel == 2'b10, "R9 pktend gating", fifo_sel, 2);
        pk_cnt++;
      end
      if (!oe_n) chk(!$isunknown(fdq), "R7 no contention", int'(fdq), 0);
      prev_oe_n = oe_n;
    end
  end

  task automatic push(int n);
    @(posedge clk); #0.5;
    for (int i = 0; i < n; i++) begin
      out_q.push_back(pat(seq));
      exp_q.push_back(pat(seq));
      seq++;
    end
  endtask

  task automatic drain(int target, string tag);
    for (int i = 0; i < 20000 && got_cnt < target; i++) @(posedge clk);
    repeat (6) @(posedge clk);
    #1;
    chk(got_cnt == target, tag, got_cnt, target);
    chk(exp_q.size() == 0, "R10 all returned", exp_q.size(), 0);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int pk0;
    void'($urandom(32'd2024));
    repeat (4) @(posedge clk);
    #1;
    chk(rd_n && wr_n && oe_n && pktend_n, "R1 strobes idle", {rd_n, wr_n, oe_n, pktend_n}, 4'hF);
    chk(!done, "R1 done low", done, 0);
    chk(fdq === 16'hzzzz, "R1 bus released", int'(fdq), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(done, "R2 done after reset", done, 1);

    push(20);
    repeat (50) @(posedge clk);
    #1;
    chk(early == 0, "R3 no traffic before sync", early, 0);
    chk(got_cnt == 0 && out_q.size() == 20, "R3 nothing moved", out_q.size(), 20);
    chk(fdq === 16'hzzzz, "R3 R7 bus idle", int'(fdq), 0);
    chk(done, "R2 done stays", done, 1);

    @(negedge clk); sync = 1'b1;
    pk0 = pk_cnt;
    drain(20, "R10 short burst count");
    chk(pk_cnt - pk0 == 1, "R9 short packet pulse", pk_cnt - pk0, 1);

    throttle = 1'b1;
    peak = 0; pk0 = pk_cnt;
    push(256);
    drain(276, "R10 full burst count");
    chk(peak == 256, "R5 full peak", peak, 256);
    chk(pk_cnt - pk0 == 0, "R9 no pulse when full", pk_cnt - pk0, 0);

    peak = 0; pk0 = pk_cnt;
    push(300);
    drain(576, "R8 R10 over-depth burst");
    chk(peak == 256, "R5 R8 peak bounded", peak, 256);
    chk(pk_cnt - pk0 == 1, "R9 tail pulse", pk_cnt - pk0, 1);

    pk0 = pk_cnt;
    push(1);
    drain(577, "R8 single word");
    chk(pk_cnt - pk0 == 1, "R9 single word pulse", pk_cnt - pk0, 1);

    for (int k = 0; k < 8; k++) begin
      push(1 + ($urandom % 3));
      repeat ($urandom % 9) @(posedge clk);
    end
    drain(seq, "R10 trickle stream");
    chk(occ == 0, "R8 buffer emptied", occ, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule